// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block is the command front end of a byte-wide NOR flash. It watches host write cycles (address plus data byte), recognises the keyed multi-cycle command sequences, and turns them into one-cycle requests for the embedded program/erase controller: start a byte program, start a chip or sector erase, suspend an erase, resume it. It tracks the operating mode (read, identification, program busy, sector-load window, erase busy, suspended, program during suspend). In each mode it accepts only the commands that are legal there and drops or aborts on the rest.

Writes arrive on a valid/ready stream. `wr_ready` is held high at all times, so the block never applies back-pressure. A write in a mode that ignores it is consumed and dropped, not stalled. The controller reports the end of an operation with `ctl_done`. The latched program address and data, the erase sector bitmask and the chip-erase flag are held as levels next to the request pulses. In identification mode, `id_data` gives the manufacturer code, the device code or the protection state, selected by the two lowest read address bits.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset, `mode` is 0 (read), `sector_mask` is 0, `id_data` is 0 and every request pulse is low.
- R2: The unlock keys are data AA with address low 11 bits 0x555, then data 55 with low bits 0x2AA. Address bits 16..11 of unlock and command cycles are ignored.
- R3: The sequence AA, 55, A0@555 followed by one more write latches the full 17-bit address and the data of that write into `pgm_addr`/`pgm_data`. It pulses `pgm_start` for one cycle, the cycle after the accepting edge, and sets `mode` to 2 (program) until `ctl_done`. At most one request pulse is high in any cycle.
- R4: While `mode` is 2, every write is ignored: no pulse is produced and the mode is unchanged.
- R5: The sequence AA, 55, 80@555, AA, 55, 10@555 pulses `erase_start` with `erase_chip`=1 and `sector_mask`=0x7F, and sets `mode` to 4 (erase).
- R6: The sequence AA, 55, 80@555, AA, 55, then 30 at any address, sets bit k of `sector_mask` for the sector holding that address and sets `mode` to 3 (load window). Sector k is: 0 at 00000-0FFFF, 1 at 10000-17FFF, 2 at 18000-19FFF, 3 at 1A000-1BFFF, 4 at 1C000-1CFFF, 5 at 1D000-1DFFF, 6 at 1E000-1FFFF. With `BOTTOM_BOOT`=1 the map is mirrored. Each further 30 written within `WINDOW_CYC` cycles of the previous accepted write adds its sector and restarts the window. When the window expires, `erase_start` pulses with `erase_chip`=0.
- R7: During the load window, a write with data other than 30 or B0 returns `mode` to 0 and clears `sector_mask`. No erase is then started.
- R8: AA, 55, 90@555 sets `mode` to 1. There `id_data` is C2 for `id_addr`=0, 18 (19 when `BOTTOM_BOOT`=1) for `id_addr`=1, and {7'b0,`prot_in`} when `id_addr[1]`=1. Outside mode 1, `id_data` is 0.
- R9: A single F0 write at any address, the unlocked form AA, 55, F0@555, or a wrong address or data anywhere in a sequence returns `mode` to 0 with no request.
- R10: In mode 4, only B0 (any address) is accepted. It pulses `suspend_req` and sets `mode` to 5 (suspended). `ctl_done` in mode 4 returns `mode` to 0 and clears the mask. `sector_mask` does not change while erasing.
- R11: In mode 5, a 30 write pulses `resume_req` and returns to mode 4. AA, 55, A0@555 plus a write to an address outside the masked sectors pulses `pgm_start` and sets `mode` to 6. `ctl_done` there returns to mode 5. A program aimed at a masked sector is dropped.
- R12: A 30 write when nothing is suspended (modes 0 and 4) has no effect.
- R13: B0 during the load window closes it without a pulse and enters mode 5. The next 30 then pulses `erase_start`, not `resume_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Write cycle present |
| wr_ready | output | 1 | Always 1; the block never stalls writes |
| wr_addr | input | 17 | Write address |
| wr_data | input | 8 | Write data byte |
| id_addr | input | 2 | Low read address bits for identification reads |
| prot_in | input | 1 | Device protection state |
| ctl_done | input | 1 | Controller finished current operation |
| mode | output | 3 | 0 read, 1 ident, 2 program, 3 load window, 4 erase, 5 suspended, 6 program in suspend |
| id_data | output | 8 | Identification read data |
| pgm_start | output | 1 | Program request pulse |
| pgm_addr | output | 17 | Latched program address |
| pgm_data | output | 8 | Latched program data |
| erase_start | output | 1 | Erase request pulse |
| erase_chip | output | 1 | Current erase covers the whole chip |
| sector_mask | output | 7 | Sectors selected for erase |
| suspend_req | output | 1 | Erase suspend pulse |
| resume_req | output | 1 | Erase resume pulse |

## Verification
The assertions assume that `ctl_done` arrives only while an operation is running (modes 2, 4 or 6) and never in the same cycle as a write. They also assume `wr_valid` is a plain level sampled at the clock edge, with address and data stable while it is high. The stimulus drives one write per two cycles and pulses `ctl_done` only in idle gaps after a program or erase has been requested. Each test waits past the load window only when the window is meant to expire.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
  localparam int ADDR_W   = 17;
  localparam int DATA_W   = 8;
  localparam int NUM_SECT = 7;
  localparam int KEY_W    = 11;

  localparam logic [KEY_W-1:0]  KEY_ADDR_A = 11'h555;
  localparam logic [KEY_W-1:0]  KEY_ADDR_B = 11'h2AA;
  localparam logic [DATA_W-1:0] KEY_DATA_A = 8'hAA;
  localparam logic [DATA_W-1:0] KEY_DATA_B = 8'h55;
  localparam logic [DATA_W-1:0] OP_RESET   = 8'hF0;
  localparam logic [DATA_W-1:0] OP_PROG    = 8'hA0;
  localparam logic [DATA_W-1:0] OP_ERSET   = 8'h80;
  localparam logic [DATA_W-1:0] OP_IDENT   = 8'h90;
  localparam logic [DATA_W-1:0] OP_CHIP    = 8'h10;
  localparam logic [DATA_W-1:0] OP_SECT    = 8'h30;
  localparam logic [DATA_W-1:0] OP_SUSP    = 8'hB0;
  localparam logic [DATA_W-1:0] ID_MFR     = 8'hC2;
  localparam logic [DATA_W-1:0] ID_DEV_TOP = 8'h18;
  localparam logic [DATA_W-1:0] ID_DEV_BOT = 8'h19;

  typedef enum logic [2:0] {
    M_READ  = 3'd0,
    M_ID    = 3'd1,
    M_PGM   = 3'd2,
    M_LOAD  = 3'd3,
    M_ERASE = 3'd4,
    M_SUSP  = 3'd5,
    M_SPGM  = 3'd6
  } mode_e;

  typedef enum logic [3:0] {
    S_READ, S_U1, S_U2, S_PARM, S_PGM, S_E0, S_E1, S_E2,
    S_LOAD, S_ERASE, S_SUSP, S_SU1, S_SU2, S_SARM, S_SPGM, S_ID
  } seq_e;

  // Start address of sector i in the top-boot layout; index NUM_SECT is the end.
  function automatic logic [ADDR_W:0] sect_base(input int idx);
    case (idx)
      0:       return 18'h00000;
      1:       return 18'h10000;
      2:       return 18'h18000;
      3:       return 18'h1A000;
      4:       return 18'h1C000;
      5:       return 18'h1D000;
      6:       return 18'h1E000;
      default: return 18'h20000;
    endcase
  endfunction
endpackage

// File: rtl/flash_key_decode.sv
module flash_key_decode
  import flash_cmd_pkg::*;
(
  input  logic [KEY_W-1:0]  addr_lo,
  input  logic [DATA_W-1:0] data,
  output logic              key_a,
  output logic              key_b,
  output logic              at_a,
  output logic              op_reset,
  output logic              op_prog,
  output logic              op_erset,
  output logic              op_ident,
  output logic              op_chip,
  output logic              op_sect,
  output logic              op_susp
);
  assign at_a     = (addr_lo == KEY_ADDR_A);
  assign key_a    = at_a && (data == KEY_DATA_A);
  assign key_b    = (addr_lo == KEY_ADDR_B) && (data == KEY_DATA_B);
  assign op_reset = (data == OP_RESET);
  assign op_prog  = (data == OP_PROG);
  assign op_erset = (data == OP_ERSET);
  assign op_ident = (data == OP_IDENT);
  assign op_chip  = (data == OP_CHIP);
  assign op_sect  = (data == OP_SECT);
  assign op_susp  = (data == OP_SUSP);
endmodule

// File: rtl/flash_sector_map.sv
module flash_sector_map
  import flash_cmd_pkg::*;
#(
  parameter bit BOTTOM_BOOT = 1'b0
) (
  input  logic [ADDR_W-1:0]   addr,
  output logic [NUM_SECT-1:0] sect_hit
);
  logic [ADDR_W-1:0]   a_eff;
  logic [NUM_SECT-1:0] hit_raw;

  assign a_eff = BOTTOM_BOOT ? ~addr : addr;

  for (genvar i = 0; i < NUM_SECT; i++) begin : g_range
    localparam logic [ADDR_W:0] LO = sect_base(i);
    localparam logic [ADDR_W:0] HI = sect_base(i + 1);
    assign hit_raw[i] = ({1'b0, a_eff} >= LO) && ({1'b0, a_eff} < HI);
  end

  if (BOTTOM_BOOT) begin : g_mirror
    for (genvar j = 0; j < NUM_SECT; j++) begin : g_flip
      assign sect_hit[j] = hit_raw[NUM_SECT-1-j];
    end
  end else begin : g_direct
    assign sect_hit = hit_raw;
  end
endmodule

// File: rtl/flash_window_timer.sv
module flash_window_timer #(
  parameter int WINDOW_CYC = 20000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic run,
  output logic expired
);
  localparam int CW = $clog2(WINDOW_CYC + 1);
  localparam logic [CW-1:0] LIM = CW'(WINDOW_CYC - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt <= '0;
    else if (restart)         cnt <= '0;
    else if (run && cnt != LIM) cnt <= cnt + 1'b1;
  end

  assign expired = run && !restart && (cnt == LIM);
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import flash_cmd_pkg::*;
#(
  parameter bit BOTTOM_BOOT = 1'b0,
  parameter int WINDOW_CYC  = 20000
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_valid,
  output logic                wr_ready,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [DATA_W-1:0]   wr_data,
  input  logic [1:0]          id_addr,
  input  logic                prot_in,
  input  logic                ctl_done,
  output logic [2:0]          mode,
  output logic [DATA_W-1:0]   id_data,
  output logic                pgm_start,
  output logic [ADDR_W-1:0]   pgm_addr,
  output logic [DATA_W-1:0]   pgm_data,
  output logic                erase_start,
  output logic                erase_chip,
  output logic [NUM_SECT-1:0] sector_mask,
  output logic                suspend_req,
  output logic                resume_req
);
  localparam logic [DATA_W-1:0] DEV_CODE = BOTTOM_BOOT ? ID_DEV_BOT : ID_DEV_TOP;

  logic wr;
  logic key_a, key_b, at_a;
  logic op_reset, op_prog, op_erset, op_ident, op_chip, op_sect, op_susp;
  logic [NUM_SECT-1:0] hit;
  logic tmr_restart, tmr_expired;

  seq_e st, st_n;
  logic [NUM_SECT-1:0] mask_q, mask_n;
  logic chip_q, chip_n, pend_q, pend_n;
  logic [ADDR_W-1:0] pa_q, pa_n;
  logic [DATA_W-1:0] pd_q, pd_n;
  logic ps_n, es_n, ss_n, rs_n;
  logic ps_q, es_q, ss_q, rs_q;

  assign wr_ready = 1'b1;
  assign wr       = wr_valid;

  flash_key_decode u_keys (
    .addr_lo (wr_addr[KEY_W-1:0]),
    .data    (wr_data),
    .key_a   (key_a),
    .key_b   (key_b),
    .at_a    (at_a),
    .op_reset(op_reset),
    .op_prog (op_prog),
    .op_erset(op_erset),
    .op_ident(op_ident),
    .op_chip (op_chip),
    .op_sect (op_sect),
    .op_susp (op_susp)
  );

  flash_sector_map #(.BOTTOM_BOOT(BOTTOM_BOOT)) u_map (
    .addr    (wr_addr),
    .sect_hit(hit)
  );

  flash_window_timer #(.WINDOW_CYC(WINDOW_CYC)) u_win (
    .clk    (clk),
    .rst_n  (rst_n),
    .restart(tmr_restart),
    .run    (st == S_LOAD),
    .expired(tmr_expired)
  );

  always_comb begin
    st_n = st;  mask_n = mask_q;  chip_n = chip_q;  pend_n = pend_q;
    pa_n = pa_q;  pd_n = pd_q;
    ps_n = 1'b0;  es_n = 1'b0;  ss_n = 1'b0;  rs_n = 1'b0;
    tmr_restart = 1'b0;
    case (st)
      S_READ, S_ID: if (wr) st_n = key_a ? S_U1 : S_READ;
      S_U1:  if (wr) st_n = key_b ? S_U2 : S_READ;
      S_U2: if (wr) begin
        if (at_a && op_prog)       st_n = S_PARM;
        else if (at_a && op_erset) st_n = S_E0;
        else if (at_a && op_ident) st_n = S_ID;
        else                       st_n = S_READ;
      end
      S_PARM: if (wr) begin
        pa_n = wr_addr;  pd_n = wr_data;  ps_n = 1'b1;  st_n = S_PGM;
      end
      S_PGM:  if (ctl_done) st_n = S_READ;
      S_E0:  if (wr) st_n = key_a ? S_E1 : S_READ;
      S_E1:  if (wr) st_n = key_b ? S_E2 : S_READ;
      S_E2: if (wr) begin
        if (at_a && op_chip) begin
          mask_n = '1;  chip_n = 1'b1;  es_n = 1'b1;  st_n = S_ERASE;
        end else if (op_sect) begin
          mask_n = hit;  chip_n = 1'b0;  pend_n = 1'b0;
          tmr_restart = 1'b1;  st_n = S_LOAD;
        end else begin
          st_n = S_READ;
        end
      end
      S_LOAD: begin
        if (wr) begin
          if (op_sect) begin
            mask_n = mask_q | hit;  tmr_restart = 1'b1;
          end else if (op_susp) begin
            pend_n = 1'b1;  st_n = S_SUSP;
          end else begin
            mask_n = '0;  st_n = S_READ;
          end
        end else if (tmr_expired) begin
          es_n = 1'b1;  st_n = S_ERASE;
        end
      end
      S_ERASE: begin
        if (ctl_done) begin
          mask_n = '0;  chip_n = 1'b0;  st_n = S_READ;
        end else if (wr && op_susp) begin
          ss_n = 1'b1;  st_n = S_SUSP;
        end
      end
      S_SUSP: if (wr) begin
        if (op_sect) begin
          if (pend_q) begin
            es_n = 1'b1;  pend_n = 1'b0;
          end else begin
            rs_n = 1'b1;
          end
          st_n = S_ERASE;
        end else if (key_a) begin
          st_n = S_SU1;
        end
      end
      S_SU1: if (wr) st_n = key_b ? S_SU2 : S_SUSP;
      S_SU2: if (wr) st_n = (at_a && op_prog) ? S_SARM : S_SUSP;
      S_SARM: if (wr) begin
        if ((hit & mask_q) == '0) begin
          pa_n = wr_addr;  pd_n = wr_data;  ps_n = 1'b1;  st_n = S_SPGM;
        end else begin
          st_n = S_SUSP;
        end
      end
      S_SPGM: if (ctl_done) st_n = S_SUSP;
      default: st_n = S_READ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_READ;  mask_q <= '0;  chip_q <= 1'b0;  pend_q <= 1'b0;
      pa_q <= '0;  pd_q <= '0;
      ps_q <= 1'b0;  es_q <= 1'b0;  ss_q <= 1'b0;  rs_q <= 1'b0;
    end else begin
      st <= st_n;  mask_q <= mask_n;  chip_q <= chip_n;  pend_q <= pend_n;
      pa_q <= pa_n;  pd_q <= pd_n;
      ps_q <= ps_n;  es_q <= es_n;  ss_q <= ss_n;  rs_q <= rs_n;
    end
  end

  always_comb begin
    case (st)
      S_ID:                        mode = M_ID;
      S_PGM:                       mode = M_PGM;
      S_LOAD:                      mode = M_LOAD;
      S_ERASE:                     mode = M_ERASE;
      S_SUSP, S_SU1, S_SU2, S_SARM: mode = M_SUSP;
      S_SPGM:                      mode = M_SPGM;
      default:                     mode = M_READ;
    endcase
  end

  always_comb begin
    if (st != S_ID)      id_data = '0;
    else if (id_addr[1]) id_data = {{(DATA_W-1){1'b0}}, prot_in};
    else if (id_addr[0]) id_data = DEV_CODE;
    else                 id_data = ID_MFR;
  end

  assign pgm_start   = ps_q;
  assign pgm_addr    = pa_q;
  assign pgm_data    = pd_q;
  assign erase_start = es_q;
  assign erase_chip  = chip_q;
  assign sector_mask = mask_q;
  assign suspend_req = ss_q;
  assign resume_req  = rs_q;
endmodule

// File: rtl/flash_cmd_decoder_chk.sv
module flash_cmd_decoder_chk
  import flash_cmd_pkg::*;
#(
  parameter bit BOTTOM_BOOT = 1'b0
) (
  input logic                clk,
  input logic                rst_n,
  input logic                ctl_done,
  input logic [2:0]          mode,
  input logic [DATA_W-1:0]   id_data,
  input logic                pgm_start,
  input logic [ADDR_W-1:0]   pgm_addr,
  input logic                erase_start,
  input logic                erase_chip,
  input logic [NUM_SECT-1:0] sector_mask,
  input logic                suspend_req,
  input logic                resume_req
);
  logic [NUM_SECT-1:0] pgm_sect;

  flash_sector_map #(.BOTTOM_BOOT(BOTTOM_BOOT)) u_chk_map (
    .addr    (pgm_addr),
    .sect_hit(pgm_sect)
  );

  p_pulse_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pgm_start, erase_start, suspend_req, resume_req}));

  p_pgm_start_mode_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pgm_start |-> (mode == M_PGM || mode == M_SPGM));

  p_pgm_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_PGM && !ctl_done) |=> (mode == M_PGM));

  p_chip_mask_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (erase_start && erase_chip) |-> (sector_mask == {NUM_SECT{1'b1}}));

  p_erase_mode_r6: assert property (@(posedge clk) disable iff (!rst_n)
    erase_start |-> (mode == M_ERASE && sector_mask != '0));

  p_id_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != M_ID) |-> (id_data == '0));

  p_suspend_src_r10: assert property (@(posedge clk) disable iff (!rst_n)
    suspend_req |-> ($past(mode) == M_ERASE && mode == M_SUSP));

  p_mask_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_ERASE && $past(mode) == M_ERASE) |-> $stable(sector_mask));

  p_resume_src_r11: assert property (@(posedge clk) disable iff (!rst_n)
    resume_req |-> ($past(mode) == M_SUSP && mode == M_ERASE));

  p_spgm_target_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (pgm_start && mode == M_SPGM) |-> ((pgm_sect & sector_mask) == '0));
endmodule

bind flash_cmd_decoder flash_cmd_decoder_chk #(.BOTTOM_BOOT(BOTTOM_BOOT)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .ctl_done   (ctl_done),
  .mode       (mode),
  .id_data    (id_data),
  .pgm_start  (pgm_start),
  .pgm_addr   (pgm_addr),
  .erase_start(erase_start),
  .erase_chip (erase_chip),
  .sector_mask(sector_mask),
  .suspend_req(suspend_req),
  .resume_req (resume_req)
);

// File: tb/flash_cmd_decoder_tb_top.sv
module flash_cmd_decoder_tb_top;
  localparam int WIN = 24;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0;
  logic        wr_ready;
  logic [16:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic [1:0]  id_addr = '0;
  logic        prot_in = 1'b0;
  logic        ctl_done = 1'b0;
  logic [2:0]  mode;
  logic [7:0]  id_data;
  logic        pgm_start, erase_start, erase_chip, suspend_req, resume_req;
  logic [16:0] pgm_addr;
  logic [7:0]  pgm_data;
  logic [6:0]  sector_mask;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  typedef struct {
    int          kind;   // 1 program, 2 erase, 3 suspend, 4 resume
    logic [16:0] addr;
    logic [7:0]  data;
    logic [6:0]  mask;
    logic        chip;
    string       req;
  } ev_t;
  ev_t exp_q[$];

  always #2 clk = ~clk;

  flash_cmd_decoder #(.BOTTOM_BOOT(1'b0), .WINDOW_CYC(WIN)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .id_addr(id_addr), .prot_in(prot_in),
    .ctl_done(ctl_done), .mode(mode), .id_data(id_data), .pgm_start(pgm_start),
    .pgm_addr(pgm_addr), .pgm_data(pgm_data), .erase_start(erase_start),
    .erase_chip(erase_chip), .sector_mask(sector_mask), .suspend_req(suspend_req),
    .resume_req(resume_req)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push(input int kind, input logic [16:0] a, input logic [7:0] d,
                      input logic [6:0] m, input logic c, input string req);
    ev_t e;
    e.kind = kind; e.addr = a; e.data = d; e.mask = m; e.chip = c; e.req = req;
    exp_q.push_back(e);
  endtask

  task automatic wr(input logic [16:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic done_pulse();
    @(negedge clk); ctl_done = 1'b1;
    @(negedge clk); ctl_done = 1'b0;
  endtask

  task automatic unlock(input logic [16:0] hi);
    wr(hi | 17'h00555, 8'hAA);
    wr(hi | 17'h002AA, 8'h55);
  endtask

  // Monitor: compares every request pulse with the head of the scoreboard.
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      int kind;
      int n;
      n = $countones({pgm_start, erase_start, suspend_req, resume_req});
      kind = pgm_start ? 1 : erase_start ? 2 : suspend_req ? 3 : resume_req ? 4 : 0;
      if (n > 1) chk("R3 single pulse", n, 1);
      if (kind != 0) begin
        if (exp_q.size() == 0) begin
          chk("R4/R12 unexpected request", kind, 0);
        end else begin
          ev_t e;
          e = exp_q.pop_front();
          chk({e.req, " kind"}, kind, e.kind);
          if (e.kind == 1) begin
            chk({e.req, " addr"}, pgm_addr, e.addr);
            chk({e.req, " data"}, pgm_data, e.data);
          end
          if (e.kind == 2) begin
            chk({e.req, " mask"}, sector_mask, e.mask);
            chk({e.req, " chip"}, erase_chip, e.chip);
          end
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    idle(3);
    // R1 reset state
    chk("R1 mode", mode, 0);
    chk("R1 mask", sector_mask, 0);
    chk("R1 id", id_data, 0);
    chk("R1 pulses", {pgm_start, erase_start, suspend_req, resume_req}, 0);
    chk("R1 ready", wr_ready, 1);
    @(negedge clk); rst_n = 1'b1;
    idle(2);

    // R2/R3 program with upper address bits set in key cycles
    wr(17'h1F555, 8'hAA);
    wr(17'h0A2AA, 8'h55);
    push(1, 17'h12345, 8'h5A, 0, 0, "R3 program");
    wr(17'h18555, 8'hA0);
    chk("R2 keys with upper bits", mode, 0);
    wr(17'h12345, 8'h5A);
    chk("R3 mode program", mode, 2);
    // R4 writes ignored while programming
    wr(17'h00000, 8'hF0);
    unlock(17'h0);
    chk("R4 mode held", mode, 2);
    done_pulse();
    chk("R3 done to read", mode, 0);

    // R8 identification
    unlock(17'h0);
    wr(17'h00555, 8'h90);
    chk("R8 mode id", mode, 1);
    id_addr = 2'd0; #1 chk("R8 mfr code", id_data, 8'hC2);
    id_addr = 2'd1; #1 chk("R8 dev code", id_data, 8'h18);
    id_addr = 2'd2; #1 chk("R8 prot 0", id_data, 8'h00);
    prot_in = 1'b1; #1 chk("R8 prot 1", id_data, 8'h01);
    // R9 single F0 anywhere
    wr(17'h1ABCD, 8'hF0);
    chk("R9 F0 exits id", mode, 0);
    chk("R8 id quiet", id_data, 8'h00);

    // R9 wrong address aborts
    wr(17'h00555, 8'hAA);
    wr(17'h002AB, 8'h55);
    wr(17'h00555, 8'hA0);
    wr(17'h00100, 8'h11);
    chk("R9 bad key abort", mode, 0);
    // R9 unlocked reset form
    unlock(17'h0);
    wr(17'h00555, 8'hF0);
    chk("R9 unlocked reset", mode, 0);
    wr(17'h00100, 8'h22);
    chk("R9 no program after reset", mode, 0);

    // R12 lone resume in read mode
    wr(17'h00000, 8'h30);
    chk("R12 resume in read", mode, 0);

    // R5 chip erase
    unlock(17'h0); wr(17'h00555, 8'h80);
    unlock(17'h0);
    push(2, 0, 0, 7'h7F, 1, "R5 chip erase");
    wr(17'h00555, 8'h10);
    chk("R5 mode erase", mode, 4);
    wr(17'h00000, 8'h30);
    chk("R12 resume while erasing", mode, 4);
    done_pulse();
    chk("R10 done to read", mode, 0);
    chk("R10 mask cleared", sector_mask, 0);

    // R6 sector erase with two sectors in the window
    unlock(17'h0); wr(17'h00555, 8'h80);
    unlock(17'h0);
    wr(17'h1C123, 8'h30);
    chk("R6 load mode", mode, 3);
    chk("R6 first sector", sector_mask, 7'h10);
    idle(WIN - 4);
    wr(17'h05000, 8'h30);
    chk("R6 second sector", sector_mask, 7'h11);
    chk("R6 still loading", mode, 3);
    push(2, 0, 0, 7'h11, 0, "R6 sector erase");
    idle(WIN + 2);
    chk("R6 erase after window", mode, 4);

    // R10 suspend, R11 program outside erased sectors, resume
    push(3, 0, 0, 0, 0, "R10 suspend");
    wr(17'h00777, 8'hB0);
    chk("R10 suspended", mode, 5);
    unlock(17'h0);
    wr(17'h00555, 8'hA0);
    push(1, 17'h1E010, 8'hC3, 0, 0, "R11 suspend program");
    wr(17'h1E010, 8'hC3);
    chk("R11 suspend program mode", mode, 6);
    done_pulse();
    chk("R11 back to suspended", mode, 5);
    unlock(17'h0);
    wr(17'h00555, 8'hA0);
    wr(17'h1C000, 8'h99);
    chk("R11 masked program dropped", mode, 5);
    push(4, 0, 0, 0, 0, "R11 resume");
    wr(17'h00000, 8'h30);
    chk("R11 resumed", mode, 4);
    chk("R10 mask kept", sector_mask, 7'h11);
    done_pulse();
    chk("R10 erase done", mode, 0);

    // R7 other command in window aborts
    unlock(17'h0); wr(17'h00555, 8'h80);
    unlock(17'h0);
    wr(17'h18000, 8'h30);
    chk("R7 load sector 2", sector_mask, 7'h04);
    wr(17'h00555, 8'hA0);
    chk("R7 abort mode", mode, 0);
    chk("R7 abort mask", sector_mask, 0);
    idle(WIN + 2);
    chk("R7 no erase later", mode, 0);

    // R13 suspend inside window
    unlock(17'h0); wr(17'h00555, 8'h80);
    unlock(17'h0);
    wr(17'h1A000, 8'h30);
    wr(17'h00000, 8'hB0);
    chk("R13 suspended from window", mode, 5);
    idle(WIN + 2);
    chk("R13 stays suspended", mode, 5);
    push(2, 0, 0, 7'h08, 0, "R13 deferred start");
    wr(17'h00000, 8'h30);
    chk("R13 erase mode", mode, 4);
    done_pulse();
    idle(2);

    chk("scoreboard drained", exp_q.size(), 0);
    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule